// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block lets synchronous logic use an external asynchronous static RAM of 128K bytes. On the client side it takes a one-word request: a valid flag, a write flag, a 17-bit address and 8 bits of write data. A `ready` output gates when a request may be offered. Read results come back on an 8-bit data bus, marked by a one-cycle valid strobe.

On the memory side the controller drives the address, two chip selects of opposite polarity, an output enable and a write enable. It also drives the outgoing data together with an enable for the pad tristate. Every wait in the sequence comes from a nanosecond parameter of the memory's speed grade, rounded up to whole clocks when the design is elaborated. A read holds the select and output enable for the access time. A write runs three phases: setup with the data already on the bus, a write-enable pulse, then a hold. After each access the memory is deselected for at least one clock before the next request is taken.

The data bus is driven only inside a write, and output enable stays high for the whole write. The controller's driver and the memory's output driver are therefore never on at the same time.

Top module: `sram_async_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the memory is deselected from the following cycle: `mem_ce_n`=1, `mem_ce2`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0. Also `req_ready`=1 and `rsp_valid`=0.
- R2: A request is taken only at a clock edge where both `req_valid` and `req_ready` are high. From the next cycle, `req_ready` stays low until the access ends. A request offered while `req_ready` is low has no effect on the memory pins.
- R3: A read keeps `mem_ce_n`=0, `mem_ce2`=1, `mem_oe_n`=0 and `mem_we_n`=1 for RD clocks, starting in the cycle after acceptance. RD = max(ceil(tAA/T), ceil(tOE/T), ceil(tRC/T)), where T is the clock period. With the defaults (T=5, tAA=55, tOE=25, tRC=55 ns), RD is 11.
- R4: `mem_dq_in` is sampled on the clock edge that ends the RD read clocks. In the next cycle `rsp_valid` is high and `rsp_rdata` holds that byte, and the strobe lasts exactly one cycle.
- R5: A write has three phases. First, WS clocks with `mem_we_n`=1, where WS = max(1, ceil(tSA/T)). Next, WP clocks with `mem_we_n`=0, where WP = max(ceil(tPWE/T), ceil(tSD/T), ceil(tAW/T)-WS, ceil(tCW/T)-WS). Last, WH clocks with `mem_we_n`=1, where WH = max(1, ceil(tHD/T), ceil(tWC/T)-WS-WP). With the defaults, WS=1, WP=8 and WH=2.
- R6: `mem_oe_n` stays high through every write. `mem_dq_oe` is high exactly during the WS+WP+WH write clocks. `mem_dq_oe` is never high while `mem_oe_n` is low.
- R7: From the cycle after acceptance until the access ends, `mem_addr` holds the accepted address. During a write, `mem_dq_out` holds the accepted data.
- R8: After every access, the memory is deselected for one clock with `req_ready` still low. `req_ready` returns high in the cycle after that.
- R9: During any access, `mem_ce_n`=0 and `mem_ce2`=1. Outside accesses, `mem_ce_n`=1 and `mem_ce2`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle, request may be taken |
| rsp_rdata | output | 8 | Read result |
| rsp_valid | output | 1 | One-cycle strobe for `rsp_rdata` |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Second chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Tristate enable for `mem_dq_out` |
| mem_dq_in | input | 8 | Data from the memory |

## Verification
The assertions check, on every cycle, the rules that hold at any single instant:
- output enable and write enable are never low together;
- the data driver is never on while output enable is low or while the chip is deselected;
- write enable low always has driven data under it;
- the address is frozen while the controller is busy;
- the read strobe lasts one cycle;
- no access returns to idle without passing through the deselect gap.

Only the bench can show the rest. It proves that the phase lengths match the rounded-up nanosecond figures, using a memory model that returns valid data only after the access time and commits a write only when the pulse, data setup and address setup were long enough. It also shows that a request held high while the controller is busy has no effect, and that written bytes read back at the extreme addresses.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
// Shared types and elaboration-time helpers for the asynchronous SRAM controller.
// Assumes all timing figures are non-negative integers in nanoseconds.
package sram_ctl_pkg;

    // Sequencer states; each non-idle state is entered once per access.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_WR_SETUP = 3'd2,
        ST_WR_PULSE = 3'd3,
        ST_WR_HOLD  = 3'd4,
        ST_GAP      = 3'd5
    } seq_state_t;

    // Round a nanosecond figure up to whole clock periods.
    function automatic int ns_to_clk(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
// Loadable down counter that measures the length of each sequencer phase.
// Assumes the loaded value is the phase length minus one; 'expired' is high
// in the last cycle of the phase.
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R5: once run out, the timer stays run out until reloaded
    timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
// Access sequencer: accepts one request at a time and steps through the read
// or write phases, then a one-clock deselect gap, before returning to idle.
// Assumes phase lengths are at least one clock and fit in CNT_W bits.
module sram_seq_fsm
    import sram_ctl_pkg::*;
#(
    parameter int RD_CYC = 11,
    parameter int WS_CYC = 1,
    parameter int WP_CYC = 8,
    parameter int WH_CYC = 2,
    parameter int CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             phase_done,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic             accept,
    output logic             capture,
    output logic             idle,
    output seq_state_t       state_d
);

    seq_state_t state_q;

    assign idle    = (state_q == ST_IDLE);
    assign accept  = idle && req_valid;
    assign capture = (state_q == ST_RD_ACC) && phase_done;

    // Next-state choice: leave a phase only when its timer has run out.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = req_write ? ST_WR_SETUP : ST_RD_ACC;
            ST_RD_ACC:   if (phase_done) state_d = ST_GAP;
            ST_WR_SETUP: if (phase_done) state_d = ST_WR_PULSE;
            ST_WR_PULSE: if (phase_done) state_d = ST_WR_HOLD;
            ST_WR_HOLD:  if (phase_done) state_d = ST_GAP;
            ST_GAP:      if (phase_done) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Phase length to load into the timer on entry to the next state.
    always_comb begin
        timer_load = (state_d != state_q);
        unique case (state_d)
            ST_RD_ACC:   timer_val = CNT_W'(RD_CYC - 1);
            ST_WR_SETUP: timer_val = CNT_W'(WS_CYC - 1);
            ST_WR_PULSE: timer_val = CNT_W'(WP_CYC - 1);
            ST_WR_HOLD:  timer_val = CNT_W'(WH_CYC - 1);
            default:     timer_val = '0;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // R8: an access never drops straight back to idle
    gap_before_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_GAP) |=> (state_q != ST_IDLE));

    // R5: the write pulse is always followed by the hold phase
    pulse_then_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_PULSE && phase_done) |=> (state_q == ST_WR_HOLD));

endmodule

// File: rtl/sram_pin_driver.sv
`timescale 1ns/1ps
// Registers every memory-side pin so the external strobes are glitch free.
// Address and write data are latched at acceptance; control levels follow the
// sequencer's next state. Assumes the pad tristate lives outside this block.
module sram_pin_driver
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              busy,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  seq_state_t        state_d,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);

    logic sel_d;
    logic wr_d;

    assign wr_d  = (state_d == ST_WR_SETUP) || (state_d == ST_WR_PULSE) ||
                   (state_d == ST_WR_HOLD);
    assign sel_d = wr_d || (state_d == ST_RD_ACC);

    // Latch address and data only when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Decode control pin levels from the state being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_ce2   <= 1'b0;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_ce_n  <= !sel_d;
            mem_ce2   <= sel_d;
            mem_oe_n  <= !(state_d == ST_RD_ACC);
            mem_we_n  <= !(state_d == ST_WR_PULSE);
            mem_dq_oe <= wr_d;
        end
    end

    // R6: output enable and write enable are never active together
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R6: no bus contention with the memory's output driver
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R9: data is driven only while the chip is selected
    drive_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_ce_n && mem_ce2));

    // R5: the write pulse always has valid data beneath it
    pulse_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    // R7: the address is frozen while the controller is busy
    addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr));

endmodule

// File: rtl/sram_read_capture.sv
`timescale 1ns/1ps
// Samples the memory's data pins at the end of a read and presents the byte
// with a one-cycle valid strobe. Assumes 'capture' is a single-cycle pulse.
module sram_read_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_valid
);

    // Register read data and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= capture;
            if (capture) begin
                rsp_rdata <= mem_dq_in;
            end
        end
    end

    // R4: the read strobe lasts a single cycle
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_async_ctl.sv
`timescale 1ns/1ps
// Top of the asynchronous SRAM controller. Converts nanosecond timing figures
// into clock counts and wires the sequencer, phase timer, pin driver and read
// capture together. Assumes a single clock; the pad tristate is external.
module sram_async_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 5,
    parameter int T_AA_NS   = 55,
    parameter int T_OE_NS   = 25,
    parameter int T_RC_NS   = 55,
    parameter int T_WC_NS   = 55,
    parameter int T_PWE_NS  = 40,
    parameter int T_AW_NS   = 45,
    parameter int T_CW_NS   = 45,
    parameter int T_SD_NS   = 25,
    parameter int T_SA_NS   = 0,
    parameter int T_HD_NS   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int RD_CYC = imax(imax(ns_to_clk(T_AA_NS, CLK_NS), ns_to_clk(T_OE_NS, CLK_NS)),
                                 imax(ns_to_clk(T_RC_NS, CLK_NS), 1));
    localparam int WS_CYC = imax(1, ns_to_clk(T_SA_NS, CLK_NS));
    localparam int WP_CYC = imax(imax(imax(ns_to_clk(T_PWE_NS, CLK_NS), ns_to_clk(T_SD_NS, CLK_NS)),
                                      imax(ns_to_clk(T_AW_NS, CLK_NS) - WS_CYC,
                                           ns_to_clk(T_CW_NS, CLK_NS) - WS_CYC)), 1);
    localparam int WH_CYC = imax(imax(1, ns_to_clk(T_HD_NS, CLK_NS)),
                                 ns_to_clk(T_WC_NS, CLK_NS) - WS_CYC - WP_CYC);
    localparam int MAX_CYC = imax(imax(RD_CYC, WS_CYC), imax(WP_CYC, WH_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             phase_done;
    logic             accept;
    logic             capture;
    logic             idle;
    seq_state_t       state_d;

    sram_seq_fsm #(
        .RD_CYC (RD_CYC),
        .WS_CYC (WS_CYC),
        .WP_CYC (WP_CYC),
        .WH_CYC (WH_CYC),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .phase_done (phase_done),
        .timer_load (timer_load),
        .timer_val  (timer_val),
        .accept     (accept),
        .capture    (capture),
        .idle       (idle),
        .state_d    (state_d)
    );

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (phase_done)
    );

    sram_pin_driver #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .busy       (!idle),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .state_d    (state_d),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_ce2    (mem_ce2),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe)
    );

    sram_read_capture #(
        .DATA_W (DATA_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .mem_dq_in (mem_dq_in),
        .rsp_rdata (rsp_rdata),
        .rsp_valid (rsp_valid)
    );

    assign req_ready = idle;

endmodule

// File: tb/tb_sram_async_ctl.sv
`timescale 1ns/1ps
module tb_sram_async_ctl;

    localparam int PER = 5;
    // Phase lengths worked out from the requirements (R3, R5)
    localparam int RD  = 11;
    localparam int WS  = 1;
    localparam int WP  = 8;
    localparam int WH  = 2;
    localparam int RTOT = RD + 1;
    localparam int WTOT = WS + WP + WH + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic [7:0]  rsp_rdata;
    logic        rsp_valid;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    always #2.5 clk = ~clk;

    sram_async_ctl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .rsp_valid(rsp_valid), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    int checks = 0;
    int fails  = 0;
    bit chk_en = 1'b0;
    bit done   = 1'b0;

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, got, exp);
        end
    endtask

    // ---------------- memory device model ----------------
    logic [7:0] dev_mem [int];
    logic [7:0] exp_mem [int];
    int          rd_age = 0;
    int          we_low = 0;
    int          dat_age = 0;
    int          adr_age = 0;
    logic [16:0] p_addr = '0;
    logic [7:0]  p_dq = '0;
    bit          p_wr = 1'b0;
    bit          p_sel = 1'b0;
    bit          p_drv = 1'b0;

    function automatic logic [7:0] dev_rd(input int a);
        return dev_mem.exists(a) ? dev_mem[a] : 8'h00;
    endfunction
    function automatic logic [7:0] exp_rd(input int a);
        return exp_mem.exists(a) ? exp_mem[a] : 8'h00;
    endfunction

    // Data is valid only once the access time has elapsed with the read held.
    assign mem_dq_in = (rd_age * PER >= 55 && !mem_ce_n && mem_ce2 && !mem_oe_n && mem_we_n)
                       ? dev_rd(int'(mem_addr)) : 8'hEE;

    // Device timing bookkeeping, sampled between edges.
    always @(negedge clk) begin
        bit sel, rd_c, wr_c;
        sel  = !mem_ce_n && mem_ce2;
        rd_c = sel && !mem_oe_n && mem_we_n;
        wr_c = sel && !mem_we_n;
        if (chk_en && mem_dq_oe && rd_c) chk("R6 bus contention", 1, 0);
        rd_age  = (rd_c && mem_addr == p_addr && rd_age > 0) ? rd_age + 1 : (rd_c ? 1 : 0);
        adr_age = (sel && mem_addr == p_addr && p_sel) ? adr_age + 1 : (sel ? 1 : 0);
        dat_age = (mem_dq_oe && mem_dq_out == p_dq && p_drv) ? dat_age + 1 : (mem_dq_oe ? 1 : 0);
        if (p_wr && !wr_c) begin
            // write ends: commit only if pulse, data and address setup were met (R5)
            chk("R5 write pulse width", int'(we_low >= WP), 1);
            chk("R5 write data setup", int'(p_drv && dat_age - 1 >= 5), 1);
            chk("R5 write address setup", int'(adr_age - 1 >= 9), 1);
            if (we_low >= WP && dat_age - 1 >= 5 && adr_age - 1 >= 9)
                dev_mem[int'(p_addr)] = p_dq;
        end
        we_low = wr_c ? we_low + 1 : 0;
        p_wr = wr_c; p_sel = sel; p_drv = mem_dq_oe; p_addr = mem_addr; p_dq = mem_dq_out;
    end

    // ---------------- cycle reference model ----------------
    int          k = 0;
    bit          op_wr = 1'b0;
    logic [16:0] op_addr = '0;
    logic [7:0]  op_data = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            k = 0;
        end else if (k == 0) begin
            if (req_valid) begin
                op_wr = req_write; op_addr = req_addr; op_data = req_wdata; k = 1;
                if (op_wr) exp_mem[int'(op_addr)] = op_data;
            end
        end else if (k == (op_wr ? WTOT : RTOT)) begin
            k = 0;
        end else begin
            k++;
        end
    end

    // Compare every output against the model on every cycle.
    always @(negedge clk) begin
        bit sel, we_lo, rv;
        if (chk_en) begin
            sel   = op_wr ? (k >= 1 && k <= WS + WP + WH) : (k >= 1 && k <= RD);
            we_lo = op_wr && k >= WS + 1 && k <= WS + WP;
            rv    = !op_wr && k == RD + 1;
            chk("R2/R8 req_ready", int'(req_ready), int'(k == 0));
            chk("R9 mem_ce_n", int'(mem_ce_n), int'(!sel));
            chk("R9 mem_ce2", int'(mem_ce2), int'(sel));
            chk("R3/R6 mem_oe_n", int'(mem_oe_n), int'(!(sel && !op_wr)));
            chk("R5 mem_we_n", int'(mem_we_n), int'(!we_lo));
            chk("R6 mem_dq_oe", int'(mem_dq_oe), int'(sel && op_wr));
            chk("R4 rsp_valid", int'(rsp_valid), int'(rv));
            if (k > 0) chk("R7 mem_addr", int'(mem_addr), int'(op_addr));
            if (sel && op_wr) chk("R7 mem_dq_out", int'(mem_dq_out), int'(op_data));
            if (rv) chk("R4 rsp_rdata", int'(rsp_rdata), int'(exp_rd(int'(op_addr))));
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
        bit r;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        do begin
            r = req_ready;
            @(negedge clk);
        end while (!r);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(PER * 150000);
        fails++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state at the pins
        chk("R1 mem_ce_n reset", int'(mem_ce_n), 1);
        chk("R1 mem_ce2 reset", int'(mem_ce2), 0);
        chk("R1 mem_oe_n reset", int'(mem_oe_n), 1);
        chk("R1 mem_we_n reset", int'(mem_we_n), 1);
        chk("R1 mem_dq_oe reset", int'(mem_dq_oe), 0);
        chk("R1 req_ready reset", int'(req_ready), 1);
        chk("R1 rsp_valid reset", int'(rsp_valid), 0);
        chk_en = 1'b1;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Writes with varied patterns, extreme addresses (R5, R7)
        issue(1'b1, 17'h00000, 8'hA5); wait_idle();
        issue(1'b1, 17'h1FFFF, 8'hFF); wait_idle();
        issue(1'b1, 17'h0AAAA, 8'h00); wait_idle();
        issue(1'b1, 17'h15555, 8'h3C); wait_idle();
        // Read back (R3, R4)
        issue(1'b0, 17'h00000, 8'h00); wait_idle();
        issue(1'b0, 17'h1FFFF, 8'h00); wait_idle();
        issue(1'b0, 17'h0AAAA, 8'h00); wait_idle();
        issue(1'b0, 17'h15555, 8'h00); wait_idle();
        issue(1'b0, 17'h01234, 8'h00); wait_idle();   // never written

        // R2: request held high while busy changes nothing until ready returns
        issue(1'b0, 17'h15555, 8'h00);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00777; req_wdata = 8'h5A;
        repeat (3) @(negedge clk);
        req_addr = 17'h00778; req_wdata = 8'h81;   // final value taken on ready (R2)
        wait_idle();
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        issue(1'b0, 17'h00778, 8'h00); wait_idle();
        issue(1'b0, 17'h00777, 8'h00); wait_idle();

        // Back-to-back alternation (R8 gap between accesses)
        for (int i = 0; i < 6; i++) begin
            issue(1'b1, 17'(i * 17'h3001), 8'(8'h11 * i + 8'h07));
            issue(1'b0, 17'(i * 17'h3001), 8'h00);
        end
        wait_idle();
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule